// File: doc/BRIEF.md
# 4B/5B Line Coder with NRZI Serialisation

This block is a paired transmit and receive line coder for a serial link. The transmit side accepts 4-bit nibbles through a valid/ready handshake. It turns each nibble into a 5-bit symbol and sends the symbol out one bit per bit tick on a single line. The line is NRZI coded. When no nibble is offered at a symbol boundary, the idle symbol is sent instead, so the line always carries legal symbols.

The receive side samples a line bit on each bit tick and removes the NRZI coding. It collects the recovered bits. A boundary strobe supplied from outside marks the tick that carries the last bit of a symbol. On that tick the five most recent bits are classified as data, control or illegal. Data symbols yield the original nibble. Control symbols raise a flag and expose the raw code. Illegal symbols raise a violation pulse. Finding the boundary and recovering the clock are left to the surrounding logic.

Top module: `line_coder_4b5b`

## Requirements
- R1: Nibble to symbol mapping (nibble: symbol): 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101.
- R2: A symbol is sent MSB first, one bit per cycle in which `bitTick` is high, taking 5 ticks per symbol. `txLine` does not change in a cycle without a tick.
- R3: `txReady` is high only in a cycle where `bitTick` is high and a new symbol starts (every fifth tick, the first one after reset). A nibble is taken when `txValid` and `txReady` are both high, and its symbol starts on that same tick.
- R4: If `txValid` is low at a symbol start, the symbol 11111 (idle) is sent.
- R5: Transmit NRZI: a 1 bit inverts `txLine` at the tick edge and a 0 bit leaves it unchanged. `txLine` resets to 0.
- R6: Receive NRZI: on each tick the recovered bit is `rxLine` XOR the level sampled on the previous tick. That stored level resets to 0. `rxLine` is ignored when there is no tick.
- R7: When `bitTick` and `rxSymEnd` are both high, the symbol is formed from the last five recovered bits, with the oldest bit as MSB. The symbol is classified, and the result appears in the next cycle. `rxDataValid`, `rxCtrl` and `rxViolation` are single-cycle pulses, and at most one of them is high.
- R8: A symbol from the R1 table gives `rxDataValid` and the matching nibble on `rxData`.
- R9: The symbols 11111, 00000, 00100, 00111, 01100, 01101, 10001, 11000 and 11001 give an `rxCtrl` pulse. `rxSymbol` holds the received code after every classified symbol.
- R10: The symbols 00001, 00010, 00011, 00101, 00110, 01000 and 10000 give an `rxViolation` pulse.
- R11: `rxSymEnd` in a cycle without a tick has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitTick | input | 1 | Bit-rate enable shared by transmit and receive |
| txData | input | 4 | Nibble to send |
| txValid | input | 1 | Nibble offered |
| txReady | output | 1 | Nibble taken this cycle if valid |
| txLine | output | 1 | NRZI coded line level |
| rxLine | input | 1 | Sampled incoming line level |
| rxSymEnd | input | 1 | Tick carries the last bit of a symbol |
| rxData | output | 4 | Decoded nibble |
| rxDataValid | output | 1 | Data symbol pulse |
| rxCtrl | output | 1 | Control or special symbol pulse |
| rxViolation | output | 1 | Illegal symbol pulse |
| rxSymbol | output | 5 | Last classified raw symbol |

## Verification
The hardest case to reach is a receiver that must ignore line activity between ticks. A boundary strobe and a level change can arrive without a tick, and a stored level that moved at that point would corrupt every later symbol without any visible sign. The bench raises the strobe and inverts the line while the tick is low. It then restores the line and sends a known data symbol, which decodes correctly only if the stored level stayed put. All 32 five-bit codes are also fed through the receiver, and all 16 nibbles plus idle are sent through the transmitter.

// File: rtl/lc4b5b_pkg.sv
package lc4b5b_pkg;
  localparam int NibW = 4;
  localparam int SymW = 5;
  localparam int NibCount = 2 ** NibW;
  localparam int CntW = $clog2(SymW);

  typedef logic [NibW-1:0] nib_t;
  typedef logic [SymW-1:0] sym_t;

  localparam sym_t SymIdle = 5'b11111;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxSample;
    logic rxEnd;
  } strobe_t;

  function automatic sym_t encNib(input nib_t n);
    sym_t s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  function automatic logic isCtrlSym(input sym_t s);
    logic r;
    case (s)
      5'b11111, 5'b00000, 5'b00100,
      5'b00111, 5'b01100, 5'b01101,
      5'b10001, 5'b11000, 5'b11001: r = 1'b1;
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import lc4b5b_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitTick,
  input  logic    rxSymEnd,
  output strobe_t st
);
  localparam logic [CntW-1:0] LastBit = CntW'(SymW - 1);

  logic [CntW-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (bitTick) begin
      bitCnt <= (bitCnt == LastBit) ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    st.txLoad   = bitTick && (bitCnt == '0);
    st.txShift  = bitTick && (bitCnt != '0);
    st.rxSample = bitTick;
    st.rxEnd    = bitTick && rxSymEnd;
  end

  AST_LOAD_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    st.txLoad |=> !st.txLoad); // R2

endmodule

// File: rtl/lc_datapath.sv
module lc_datapath
  import lc4b5b_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t st,
  input  nib_t    txData,
  input  logic    txValid,
  output logic    txLine,
  input  logic    rxLine,
  output nib_t    rxData,
  output logic    rxDataValid,
  output logic    rxCtrl,
  output logic    rxViolation,
  output sym_t    rxSymbol
);
  // transmit path
  logic [SymW-2:0] txRest;
  sym_t loadSym;
  logic curBit;

  always_comb begin
    loadSym = txValid ? encNib(txData) : SymIdle;
    curBit  = st.txLoad ? loadSym[SymW-1] : txRest[SymW-2];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRest <= '0;
      txLine <= 1'b0;
    end else begin
      if (st.txLoad) begin
        txRest <= loadSym[SymW-2:0];
      end else if (st.txShift) begin
        txRest <= {txRest[SymW-3:0], 1'b0};
      end
      if (st.txLoad || st.txShift) begin
        txLine <= txLine ^ curBit;
      end
    end
  end

  // receive path
  logic rxPrev;
  logic [SymW-2:0] rxHist;
  logic rxBit;
  sym_t rxWord;
  logic decHit;
  nib_t decNib;
  logic ctrlHit;

  always_comb begin
    rxBit   = rxLine ^ rxPrev;
    rxWord  = {rxHist, rxBit};
    ctrlHit = isCtrlSym(rxWord);
    decHit  = 1'b0;
    decNib  = '0;
    for (int i = 0; i < NibCount; i++) begin
      if (encNib(nib_t'(i)) == rxWord) begin
        decHit = 1'b1;
        decNib = nib_t'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxPrev      <= 1'b0;
      rxHist      <= '0;
      rxData      <= '0;
      rxSymbol    <= '0;
      rxDataValid <= 1'b0;
      rxCtrl      <= 1'b0;
      rxViolation <= 1'b0;
    end else begin
      if (st.rxSample) begin
        rxPrev <= rxLine;
        rxHist <= {rxHist[SymW-3:0], rxBit};
      end
      rxDataValid <= st.rxEnd && decHit;
      rxCtrl      <= st.rxEnd && !decHit && ctrlHit;
      rxViolation <= st.rxEnd && !decHit && !ctrlHit;
      if (st.rxEnd) begin
        rxSymbol <= rxWord;
        if (decHit) rxData <= decNib;
      end
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(st.txLoad || st.txShift) |=> $stable(txLine)); // R2

  AST_IDLE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (st.txLoad && !txValid) |=> (txLine != $past(txLine))); // R4

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxDataValid, rxCtrl, rxViolation})); // R7

  AST_RX_AFTER_END: assert property (@(posedge clk) disable iff (!rstN)
    (rxDataValid || rxCtrl || rxViolation) |-> $past(st.rxEnd)); // R11

endmodule

// File: rtl/line_coder_4b5b.sv
module line_coder_4b5b
  import lc4b5b_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic [3:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic       txLine,
  input  logic       rxLine,
  input  logic       rxSymEnd,
  output logic [3:0] rxData,
  output logic       rxDataValid,
  output logic       rxCtrl,
  output logic       rxViolation,
  output logic [4:0] rxSymbol
);
  strobe_t st;

  lc_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .bitTick  (bitTick),
    .rxSymEnd (rxSymEnd),
    .st       (st)
  );

  lc_datapath uPath (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .txData      (txData),
    .txValid     (txValid),
    .txLine      (txLine),
    .rxLine      (rxLine),
    .rxData      (rxData),
    .rxDataValid (rxDataValid),
    .rxCtrl      (rxCtrl),
    .rxViolation (rxViolation),
    .rxSymbol    (rxSymbol)
  );

  assign txReady = st.txLoad;

endmodule

// File: tb/line_coder_4b5b_test.sv
module line_coder_4b5b_test;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic [3:0] txData = '0;
  logic txValid = 1'b0;
  logic txReady;
  logic txLine;
  logic rxLine = 1'b0;
  logic rxSymEnd = 1'b0;
  logic [3:0] rxData;
  logic rxDataValid;
  logic rxCtrl;
  logic rxViolation;
  logic [4:0] rxSymbol;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic txLvl = 1'b0;
  logic rxLvl = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  line_coder_4b5b uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txLine(txLine),
    .rxLine(rxLine), .rxSymEnd(rxSymEnd),
    .rxData(rxData), .rxDataValid(rxDataValid), .rxCtrl(rxCtrl),
    .rxViolation(rxViolation), .rxSymbol(rxSymbol)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] expEnc(input logic [3:0] n);
    logic [4:0] s;
    case (n)
      4'h0: s = 5'b11110; 4'h1: s = 5'b01001; 4'h2: s = 5'b10100; 4'h3: s = 5'b10101;
      4'h4: s = 5'b01010; 4'h5: s = 5'b01011; 4'h6: s = 5'b01110; 4'h7: s = 5'b01111;
      4'h8: s = 5'b10010; 4'h9: s = 5'b10011; 4'hA: s = 5'b10110; 4'hB: s = 5'b10111;
      4'hC: s = 5'b11010; 4'hD: s = 5'b11011; 4'hE: s = 5'b11100; default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // 0 = data, 1 = control, 2 = illegal
  function automatic int expClass(input logic [4:0] s);
    for (int n = 0; n < 16; n++) if (expEnc(4'(n)) == s) return 0;
    if (s inside {5'b11111, 5'b00000, 5'b00100, 5'b00111, 5'b01100,
                  5'b01101, 5'b10001, 5'b11000, 5'b11001}) return 1;
    return 2;
  endfunction

  function automatic int expNib(input logic [4:0] s);
    for (int n = 0; n < 16; n++) if (expEnc(4'(n)) == s) return n;
    return 0;
  endfunction

  // Called at a negedge where a symbol start is due; returns at the next such negedge.
  task automatic txSym(input bit valid, input logic [3:0] nib, output logic [4:0] got);
    bit readyLeak = 0;
    got = '0;
    txValid = valid;
    txData = nib;
    #1;
    check(txReady === 1'b1, "R3 ready at symbol start", int'(txReady), 1);
    for (int k = 0; k < 5; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k == 0) txValid = 1'b0;
      got = {got[3:0], txLine ^ txLvl};
      txLvl = txLine;
      if (k < 4 && txReady !== 1'b0) readyLeak = 1;
    end
    check(!readyLeak, "R3 ready low mid-symbol", int'(readyLeak), 0);
  endtask

  task automatic rxSym(input logic [4:0] s);
    for (int k = 4; k >= 0; k--) begin
      rxLvl = rxLvl ^ s[k];
      rxLine = rxLvl;
      rxSymEnd = (k == 0);
      @(posedge clk);
      @(negedge clk);
    end
    rxSymEnd = 1'b0;
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [4:0] got;
    repeat (3) @(negedge clk);
    check(txLine === 1'b0, "R5 reset line level", int'(txLine), 0);
    check({rxDataValid, rxCtrl, rxViolation} === 3'b000, "R7 reset pulses low",
          int'({rxDataValid, rxCtrl, rxViolation}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(txReady === 1'b0, "R3 no ready without tick", int'(txReady), 0);
    bitTick = 1'b1;

    // transmit sweep over all nibbles (R1, R2, R5)
    for (int n = 0; n < 16; n++) begin
      txSym(1'b1, 4'(n), got);
      check(got === expEnc(4'(n)), $sformatf("R1 R5 tx nibble %0h", n), int'(got), int'(expEnc(4'(n))));
    end
    txSym(1'b0, 4'h0, got);
    check(got === 5'b11111, "R4 idle fill", int'(got), 31);

    // ticks withheld: line must hold, nibble must wait (R2, R3)
    bitTick = 1'b0;
    txValid = 1'b1;
    txData = 4'h2;
    begin
      bit moved = 0;
      for (int k = 0; k < 4; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (txLine !== txLvl || txReady !== 1'b0) moved = 1;
      end
      check(!moved, "R2 line holds without tick", int'(moved), 0);
    end
    bitTick = 1'b1;
    txSym(1'b1, 4'h2, got);
    check(got === 5'b10100, "R3 nibble taken after gap", int'(got), 20);

    // receive sweep over all 32 codes (R6..R10)
    for (int s = 0; s < 32; s++) begin
      int cls;
      rxSym(5'(s));
      cls = expClass(5'(s));
      check(rxSymbol === 5'(s), $sformatf("R9 rxSymbol %0h", s), int'(rxSymbol), s);
      check(rxDataValid === (cls == 0), $sformatf("R8 data flag %0h", s), int'(rxDataValid), int'(cls == 0));
      check(rxCtrl === (cls == 1), $sformatf("R9 ctrl flag %0h", s), int'(rxCtrl), int'(cls == 1));
      check(rxViolation === (cls == 2), $sformatf("R10 violation flag %0h", s), int'(rxViolation), int'(cls == 2));
      if (cls == 0)
        check(rxData === 4'(expNib(5'(s))), $sformatf("R8 R6 nibble %0h", s), int'(rxData), expNib(5'(s)));
    end

    // pulses last one cycle (R7)
    rxLine = rxLvl;
    @(posedge clk);
    @(negedge clk);
    check({rxDataValid, rxCtrl, rxViolation} === 3'b000, "R7 single-cycle pulse",
          int'({rxDataValid, rxCtrl, rxViolation}), 0);

    // strobe and line change without tick are ignored (R6, R11)
    bitTick = 1'b0;
    rxSymEnd = 1'b1;
    rxLine = ~rxLvl;
    @(posedge clk);
    @(negedge clk);
    check({rxDataValid, rxCtrl, rxViolation} === 3'b000, "R11 strobe without tick",
          int'({rxDataValid, rxCtrl, rxViolation}), 0);
    rxSymEnd = 1'b0;
    rxLine = rxLvl;
    bitTick = 1'b1;
    rxSym(5'b11110);
    check(rxDataValid === 1'b1 && rxData === 4'h0, "R6 level kept across gap",
          int'({rxDataValid, rxData}), 16);

    finish();
  end
endmodule